// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that gives a host read and write access to a bank of byte-wide configuration registers. A transfer is framed by an active-low chip select. The host first shifts in an instruction that carries a direction flag, a byte count of one to four and a start address. The data bytes follow. Between bytes, an internal address generator moves the address up or down, depending on the selected bit order.

Register 0 configures the port itself. It selects the read-data pin (a separate output line, or the shared data line in 3-wire use), the bit order, a soft reset and a two-byte instruction format. Each of these settings acts from the clock edge on which its byte is committed, including inside the transfer that writes it.

The serial inputs are assumed to be already synchronous to `clk`, which must run at least six times faster than the serial clock. All register contents are visible in parallel on `reg_view`.

Top module: `spi_cfg_slave`

## Requirements
- R1: After a synchronous reset, register 0 reads 0x00 and every other register i holds ((i*29) xor 0x5A) mod 256. Both output enables are low.
- R2: A short instruction is 8 bits. Bit 7 is the direction (1 means read), bits 6:5 are the count code (00, 01, 10 and 11 mean 1, 2, 3 and 4 bytes) and bits 4:0 are the start address. Data is sampled on rising serial-clock edges while chip select is low.
- R3: With register 0 bit 6 clear, the instruction and data bits travel most significant bit first, and the address decreases by one after each data byte.
- R4: With register 0 bit 6 set, the instruction and data bits travel least significant bit first, and the address increases by one after each data byte.
- R5: Address stepping stops at 0x00 when counting down and at 0x1F when counting up. Further bytes of the same transfer reuse that address.
- R6: Read data is driven only during the data bytes of a read. It leaves on `sdo_out` when register 0 bit 7 is 0 and on `sdio_out` when that bit is 1. At most one output enable is high, and neither is high while chip select is high.
- R7: The first read bit is presented after the rising edge that samples the last instruction bit. Each later bit is presented after the next rising edge, and the output holds between edges.
- R8: A byte written to register 0 takes effect at its last bit. The step that follows that byte still uses the earlier order, and every later bit of the same transfer uses the new order.
- R9: While register 0 bit 5 is set, every register except 0 and 4 is held at its reset value and writes to those registers are ignored.
- R10: With register 0 bit 4 set, the instruction is 16 bits. Bit 15 is the direction, bits 14:13 are the count code and bits 12:0 are the address. Writes to addresses 0x20 and above change nothing, and reads from them return 0x00.
- R11: Raising chip select in the middle of a transfer discards a partly shifted byte. The next transfer starts with a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low transfer frame |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Read data for the shared line in 3-wire mode |
| sdio_oe | output | 1 | Drive enable of the shared line |
| sdo_out | output | 1 | Read data for the separate output line |
| sdo_oe | output | 1 | Drive enable of the separate output line |
| reg_view | output | NUM_REGS*8 | All registers in parallel, register i in bits 8i+7:8i |

## Verification
The bench builds the block with its default 32 registers and keeps register 4 across a soft reset. With that size, every address the short instruction can name has a register behind it. This lets the bench sweep writes and reads over the full short address space in both bit orders and with all four byte counts. The start addresses are chosen so that multi-byte transfers run into both saturation limits. The 13-bit long address then reaches the empty space above the bank, where ignored writes and zero reads can be checked.

// File: rtl/spi_cfg_pkg.sv
// Shared definitions of the serial configuration port: transfer phases,
// fixed instruction field widths, register 0 bit positions and reset values.
package spi_cfg_pkg;
    typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;

    localparam int LADDR_W  = 13;  // address width of the long instruction
    localparam int CFG_DIR  = 7;   // read data on the shared line
    localparam int CFG_LSB  = 6;   // least significant bit first
    localparam int CFG_SRST = 5;   // soft reset, level held
    localparam int CFG_LONG = 4;   // two-byte instruction

    // Reset value of register idx; register 0 clears to all zero.
    function automatic logic [7:0] reg_default(input int idx);
        return (idx == 0) ? 8'h00 : 8'((idx * 29) ^ 90);
    endfunction
endpackage

// File: rtl/spi_cfg_addr_step.sv
// Byte address generator: moves the address one step up or down and
// saturates at 0 and at TOP_ADDR. It assumes that addresses above
// TOP_ADDR have no register and stay where they are when counting up.
module spi_cfg_addr_step
    import spi_cfg_pkg::*;
#(
    parameter int TOP_ADDR = 31
) (
    input  logic [LADDR_W-1:0] cur,
    input  logic               up,
    output logic [LADDR_W-1:0] nxt
);
    localparam logic [LADDR_W-1:0] TOP = LADDR_W'(TOP_ADDR);

    // Pick the next address and hold it at either limit.
    always_comb begin
        if (up) nxt = (cur < TOP) ? cur + 1'b1 : cur;
        else    nxt = (cur != '0) ? cur - 1'b1 : cur;
    end
endmodule

// File: rtl/spi_cfg_frame.sv
// Transfer sequencer: collects the instruction, counts data bits and
// bytes, and issues register writes and read selections. It assumes that
// `rise` marks one clk cycle per serial-clock rising edge while csb is low.
// Chip select high clears all state, which drops any partial byte.
module spi_cfg_frame
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csb,
    input  logic               rise,
    input  logic               din,
    input  logic               lsb_first,
    input  logic               long_ins,
    output logic               wr_en,
    output logic [LADDR_W-1:0] wr_addr,
    output logic [7:0]         wr_data,
    output logic               rd_active,
    output logic [LADDR_W-1:0] rd_addr,
    output logic [2:0]         rd_bit_sel
);
    phase_t             phase;
    logic [3:0]         cnt;
    logic [15:0]        ins, ins_nxt;
    logic [2:0]         bcnt, data_pos;
    logic [7:0]         dbyte, dbyte_nxt;
    logic               rw, dec_rw;
    logic [1:0]         left, dec_n;
    logic [LADDR_W-1:0] addr, dec_addr, addr_nxt;
    logic [3:0]         ins_last, ins_pos;
    logic               byte_end;

    // Place the incoming instruction bit according to the current order.
    always_comb begin
        ins_last = long_ins ? 4'd15 : 4'd7;
        ins_pos  = lsb_first ? cnt : (ins_last - cnt);
        ins_nxt  = ins;
        ins_nxt[ins_pos] = din;
    end

    // Split the completed instruction into direction, count and address.
    always_comb begin
        if (long_ins) begin
            dec_rw   = ins_nxt[15];
            dec_n    = ins_nxt[14:13];
            dec_addr = ins_nxt[12:0];
        end else begin
            dec_rw   = ins_nxt[7];
            dec_n    = ins_nxt[6:5];
            dec_addr = {{(LADDR_W-5){1'b0}}, ins_nxt[4:0]};
        end
    end

    // Place the incoming data bit and flag the last bit of a byte.
    always_comb begin
        data_pos  = lsb_first ? bcnt : (3'd7 - bcnt);
        dbyte_nxt = dbyte;
        dbyte_nxt[data_pos] = din;
        byte_end  = rise && (phase == PH_DATA) && (bcnt == 3'd7);
    end

    spi_cfg_addr_step #(.TOP_ADDR(NUM_REGS - 1)) u_step (
        .cur (addr),
        .up  (lsb_first),
        .nxt (addr_nxt)
    );

    assign wr_en      = byte_end && !rw;
    assign wr_addr    = addr;
    assign wr_data    = dbyte_nxt;
    assign rd_active  = (phase == PH_DATA) && rw;
    assign rd_addr    = addr;
    assign rd_bit_sel = data_pos;

    // Sequence the instruction and data phases of one framed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || csb) begin
            phase <= PH_INSTR;
            cnt   <= '0;
            ins   <= '0;
            bcnt  <= '0;
            dbyte <= '0;
            rw    <= 1'b0;
            left  <= '0;
            addr  <= '0;
        end else if (rise) begin
            case (phase)
                PH_INSTR: begin
                    ins <= ins_nxt;
                    if (cnt == ins_last) begin
                        phase <= PH_DATA;
                        cnt   <= '0;
                        bcnt  <= '0;
                        rw    <= dec_rw;
                        left  <= dec_n;
                        addr  <= dec_addr;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    dbyte <= dbyte_nxt;
                    bcnt  <= bcnt + 1'b1;
                    if (bcnt == 3'd7) begin
                        addr <= addr_nxt;
                        if (left == 2'd0) phase <= PH_DONE;
                        else              left  <= left - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Counting down never raises the address.
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && !lsb_first) |=> (addr <= $past(addr)));
    // Counting up never lowers the address within a frame.
    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && lsb_first) |=> (csb || addr >= $past(addr)));
    // Counting up from the top register keeps the address.
    assert_top_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && lsb_first && addr == LADDR_W'(NUM_REGS - 1))
        |=> (csb || addr == $past(addr)));
    // No write is issued while the frame is closed.
    assert_no_write_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        csb |-> !wr_en);
endmodule

// File: rtl/spi_cfg_regbank.sv
// Register bank: NUM_REGS byte registers with synchronous reset. Soft reset
// is held while register 0 bit CFG_SRST is set and spares register 0 and
// KEEP_REG. Addresses at or above NUM_REGS read as zero and ignore writes.
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int KEEP_REG = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [LADDR_W-1:0]    wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [LADDR_W-1:0]    rd_addr,
    output logic [7:0]            rd_data,
    output logic [7:0]            cfg,
    output logic [NUM_REGS*8-1:0] view
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [7:0] regs [NUM_REGS];

    // Update every register from reset, soft reset or a host write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n)
                regs[i] <= reg_default(i);
            else if (i != 0 && i != KEEP_REG && regs[0][CFG_SRST])
                regs[i] <= reg_default(i);
            else if (wr_en && wr_addr == LADDR_W'(i))
                regs[i] <= wr_data;
        end
    end

    // Select read data, returning zero for empty addresses.
    always_comb begin
        if (rd_addr < LADDR_W'(NUM_REGS)) rd_data = regs[rd_addr[IDX_W-1:0]];
        else                              rd_data = 8'h00;
    end

    assign cfg = regs[0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
        assign view[g*8 +: 8] = regs[g];
    end

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_srst_chk
        if (g != KEEP_REG) begin : g_held
            // A held soft reset leaves the register at its reset value.
            assert_srst_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
                regs[0][CFG_SRST] |=> (regs[g] == reg_default(g)));
        end
    end

    // A write to an empty address leaves the whole bank unchanged.
    assert_oob_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= LADDR_W'(NUM_REGS) && !regs[0][CFG_SRST]) |=> $stable(view));
endmodule

// File: rtl/spi_cfg_slave.sv
// Top of the serial configuration port. It detects serial-clock rising
// edges in the clk domain and connects the sequencer to the register bank.
// It steers read data to one of two pins. It assumes that sclk, csb and
// sdio_in are synchronous to clk and that each serial-clock phase lasts at
// least two clk cycles.
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int KEEP_REG = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  csb,
    input  logic                  sdio_in,
    output logic                  sdio_out,
    output logic                  sdio_oe,
    output logic                  sdo_out,
    output logic                  sdo_oe,
    output logic [NUM_REGS*8-1:0] reg_view
);
    logic               sclk_q, rise, drive, rd_bit;
    logic               wr_en, rd_active;
    logic [LADDR_W-1:0] wr_addr, rd_addr;
    logic [7:0]         wr_data, rd_data, cfg;
    logic [2:0]         rd_bit_sel;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk && !sclk_q && !csb;

    spi_cfg_frame #(.NUM_REGS(NUM_REGS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .csb        (csb),
        .rise       (rise),
        .din        (sdio_in),
        .lsb_first  (cfg[CFG_LSB]),
        .long_ins   (cfg[CFG_LONG]),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_active  (rd_active),
        .rd_addr    (rd_addr),
        .rd_bit_sel (rd_bit_sel)
    );

    spi_cfg_regbank #(.NUM_REGS(NUM_REGS), .KEEP_REG(KEEP_REG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg),
        .view    (reg_view)
    );

    // Steer the selected read bit to the pin chosen by the direction bit.
    always_comb begin
        drive    = rd_active && !csb;
        rd_bit   = rd_data[rd_bit_sel];
        sdo_oe   = drive && !cfg[CFG_DIR];
        sdio_oe  = drive && cfg[CFG_DIR];
        sdo_out  = sdo_oe && rd_bit;
        sdio_out = sdio_oe && rd_bit;
    end

    // Both pins are released while the frame is closed.
    assert_idle_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        csb |-> (!sdo_oe && !sdio_oe));
    // Never both pins driven.
    assert_one_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdo_oe, sdio_oe}));
    // Read data only moves after a serial-clock rising edge.
    assert_hold_between_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && $past(drive) && !$past(rise)) |-> ($stable(sdo_out) && $stable(sdio_out)));
endmodule

// File: tb/tb_spi_cfg_slave.sv
module tb_spi_cfg_slave;
    logic         clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csb = 1'b1, sdio_in = 1'b0;
    logic         sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [255:0] reg_view;

    int         checks = 0, errors = 0;
    logic [7:0] model [32];
    bit         m_lsb = 0, m_dir = 0, m_long = 0, m_srst = 0;
    bit         done = 0;

    spi_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .reg_view(reg_view)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] dflt(input int i);
        return (i == 0) ? 8'h00 : 8'((i * 29) ^ 90);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 32; i++) chk(req, 32'(reg_view[i*8 +: 8]), 32'(model[i]));
    endtask

    // Expected effect of one committed data byte.
    task automatic model_write(input int a, input logic [7:0] v);
        if (a >= 32) return;
        if (m_srst && a != 0 && a != 4) return;
        model[a] = v;
        if (a == 0) begin
            m_dir = v[7]; m_lsb = v[6]; m_srst = v[5]; m_long = v[4];
            if (m_srst)
                for (int i = 1; i < 32; i++) if (i != 4) model[i] = dflt(i);
        end
    endtask

    // One serial bit; o is the read line sampled before the rising edge.
    task automatic bit_io(input logic b, output logic o, output logic oe_ok);
        @(negedge clk) sdio_in = b;
        repeat (2) @(negedge clk);
        o     = m_dir ? sdio_out : sdo_out;
        oe_ok = m_dir ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xfer(input string req, input bit rd, input int n, input int addr,
                        input logic [31:0] wd);
        logic [15:0] insv;
        logic [7:0]  got;
        logic        o, ok, all_ok;
        int          w, a, a_next;
        @(negedge clk) csb = 1'b0;
        insv = m_long ? {rd, 2'(n - 1), 13'(addr)} : {8'd0, rd, 2'(n - 1), 5'(addr)};
        w = m_long ? 16 : 8;
        for (int i = 0; i < w; i++) bit_io(insv[m_lsb ? i : w - 1 - i], o, ok);
        a = addr;
        for (int k = 0; k < n; k++) begin
            all_ok = 1'b1;
            got = 8'h00;
            for (int j = 0; j < 8; j++) begin
                int pos;
                pos = m_lsb ? j : 7 - j;
                bit_io(wd[8*k + pos], o, ok);
                got[pos] = o;
                all_ok = all_ok & ok;
            end
            if (m_lsb) a_next = (a < 31) ? a + 1 : a;
            else       a_next = (a > 0) ? a - 1 : a;
            if (rd) begin
                chk(req, 32'(got), (a < 32) ? 32'(model[a]) : 32'h0);
                chk({req, " R6 enable"}, 32'(all_ok), 32'h1);
            end else begin
                model_write(a, wd[8*k +: 8]);
            end
            a = a_next;
        end
        @(negedge clk) csb = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Shift raw bits most significant first, then close the frame.
    task automatic partial(input int nbits, input logic [15:0] pat);
        logic o, ok;
        @(negedge clk) csb = 1'b0;
        for (int i = nbits - 1; i >= 0; i--) bit_io(pat[i], o, ok);
        @(negedge clk) csb = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = dflt(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check_all("R1");
        chk("R1 enables", {30'd0, sdo_oe, sdio_oe}, 32'h0);

        // R2 single-byte sweep over the short address space
        for (int a = 1; a < 32; a++) xfer("R2 write", 0, 1, a, 32'((a * 53 + 17) & 255));
        check_all("R2");
        for (int a = 0; a < 32; a++) xfer("R2 read", 1, 1, a, 32'h0);

        // R3 most significant first, decrementing, every byte count
        for (int n = 1; n <= 4; n++)
            for (int s = 0; s < 3; s++) begin
                int st;
                st = (s == 0) ? 6 : (s == 1) ? 17 : 31;
                xfer("R3 write", 0, n, st, 32'(32'h9E3779B9 * (n * 3 + s + 1)));
                check_all("R3");
                xfer("R3 read", 1, n, st, 32'h0);
            end
        // R5 downward saturation at register 0
        xfer("R5 read low", 1, 4, 1, 32'h0);
        xfer("R7 read timing", 1, 2, 20, 32'h0);

        // R4 least significant first, incrementing
        xfer("R4 cfg", 0, 1, 0, 32'h40);
        check_all("R4 cfg");
        for (int n = 1; n <= 4; n++)
            for (int s = 0; s < 3; s++) begin
                int st;
                st = (s == 0) ? 5 : (s == 1) ? 20 : 29;
                xfer("R4 write", 0, n, st, 32'(32'h7F4A7C15 * (n * 5 + s + 2)));
                check_all("R4");
                xfer("R4 read", 1, n, st, 32'h0);
            end
        // R5 upward saturation at 0x1F
        xfer("R5 read high", 1, 4, 30, 32'h0);

        // R8 switch to most significant first inside one transfer
        xfer("R8 write", 0, 2, 0, 32'h9600);
        check_all("R8");
        chk("R8 reg1", 32'(reg_view[15:8]), 32'h96);

        // R6 read data on the shared line
        xfer("R6 cfg", 0, 1, 0, 32'h80);
        for (int a = 3; a < 32; a += 7) xfer("R6 read", 1, 3, a, 32'h0);
        xfer("R6 read cfg", 1, 1, 0, 32'h0);

        // R10 long instruction and empty addresses
        xfer("R10 cfg", 0, 1, 0, 32'h10);
        xfer("R10 oob write", 0, 1, 13'h0123, 32'h55);
        check_all("R10 oob");
        xfer("R10 oob read", 1, 1, 13'h0123, 32'h0);
        xfer("R10 write", 0, 2, 9, 32'hC3A5);
        check_all("R10");
        xfer("R10 read", 1, 2, 10, 32'h0);
        xfer("R10 cfg lsb", 0, 1, 0, 32'h50);
        xfer("R10 lsb write", 0, 2, 12, 32'h3C5A);
        check_all("R10 lsb");
        xfer("R10 lsb read", 1, 3, 11, 32'h0);
        xfer("R10 back", 0, 1, 0, 32'h00);
        check_all("R10 back");

        // R11 aborted frames
        partial(13, {3'b0, 8'b0000_0011, 5'b10110});
        check_all("R11 data abort");
        partial(4, 16'h0005);
        xfer("R11 after abort", 0, 1, 7, 32'hE1);
        check_all("R11");

        // R9 soft reset
        xfer("R9 w4", 0, 1, 4, 32'hAB);
        xfer("R9 w5", 0, 1, 5, 32'h12);
        xfer("R9 set", 0, 1, 0, 32'h20);
        check_all("R9 set");
        xfer("R9 blocked", 0, 1, 6, 32'h77);
        xfer("R9 keep", 0, 1, 4, 32'h3C);
        check_all("R9 hold");
        xfer("R9 clear", 0, 1, 0, 32'h00);
        xfer("R9 after", 0, 1, 6, 32'h77);
        check_all("R9 after");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule